// File: doc/BRIEF.md
# Two-Wire Port Expander Slave Controller

This block is the serial slave front end of an 8-bit port expander that also carries a 6-bit converter control register. A system clock oversamples the two-wire bus lines (SCL and SDA). The block finds START and STOP conditions and compares the received 7-bit address with a fixed upper nibble of 0111 followed by three strap inputs. A write carries one or two data bytes. The first goes to the port output register. The second goes to a control register that holds a latch mode bit, a threshold select bit and the converter code.

A read returns status bytes from an external capture block. At every acknowledge that follows the read address, and at every master acknowledge of a read byte, the block sends that capture block a one-cycle strobe. At the end of that acknowledge clock it loads the capture block's byte into its transmit shifter. The comparators, the converter and the pad drivers are outside the block. The block pulls SDA low through a single open-drain enable.

The controller is one state machine. Its states are:

- `ST_IDLE`: waiting for a START.
- `ST_ADDR`: receiving the address byte.
- `ST_ADDR_ACK`: acknowledging a matching address.
- `ST_WR_BYTE`: receiving a write byte.
- `ST_WR_ACK`: acknowledging a write byte.
- `ST_RD_BYTE`: shifting out a status byte.
- `ST_RD_ACK`: sampling the master's acknowledge.
- `ST_IGNORE`: bus released until the next START or STOP.

Its transitions are:

- IDLE→ADDR on START.
- ADDR→ADDR_ACK on a match, or ADDR→IGNORE on a mismatch, at the SCL fall after the eighth bit.
- ADDR_ACK→RD_BYTE or ADDR_ACK→WR_BYTE at the end of the acknowledge clock.
- WR_BYTE→WR_ACK for the first two bytes, or WR_BYTE→IGNORE for a third byte.
- WR_ACK→WR_BYTE at the end of the acknowledge clock.
- RD_BYTE→RD_ACK after eight bits.
- RD_ACK→RD_BYTE on a master acknowledge, or RD_ACK→IGNORE on a NACK.
- Any state→IDLE on STOP, and any state→ADDR on a repeated START.

Top module: `iox_slave`

## Requirements
- R1: After reset, `port_out` is 0x00, `latch_mode`, `thr_sel` (0 selects the half-supply reference) and `dac_code` are 0, `sda_pull` is 0 and `rd_strobe` is 0.
- R2: An address byte whose bits 7..4 are 0111, whose bits 3..1 equal `strap_a[2:0]` and whose bit 0 is R/W (0 write, 1 read) is acknowledged: SDA is pulled low during the ninth clock. SDA changes only while SCL is low.
- R3: An address that does not match is not acknowledged. Every later byte in that transaction is also not acknowledged and changes no register, until the next START or STOP.
- R4: The first write byte is acknowledged and loaded into `port_out`, with bit n driving port pin n. The load happens at the acknowledge of that byte.
- R5: The second write byte is loaded at its acknowledge into the control register: bit 7 goes to `latch_mode`, bit 6 to `thr_sel` and bits 5..0 to `dac_code`.
- R6: A write of one data byte leaves the control register unchanged.
- R7: A third write byte in one transaction is not acknowledged and changes neither register.
- R8: Each read byte is shifted out MSB first. It is the `stat_byte` value loaded at the end of the acknowledge clock that preceded it. A read may return one byte or several bytes.
- R9: `rd_strobe` is high for one clock at the acknowledge of a read address and at each master acknowledge (SDA low) of a read byte. A master NACK raises no strobe.
- R10: A STOP or repeated START in the middle of a byte aborts that byte without updating any register. A repeated START starts a new address phase.
- R11: After a master NACK on a read, the slave releases SDA and drives nothing until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_a | input | 3 | Low three address bits from strap pins |
| stat_byte | input | 8 | Status byte from the capture block |
| rd_strobe | output | 1 | One-cycle capture/reset strobe at read acknowledges |
| port_out | output | 8 | Port output register |
| latch_mode | output | 1 | Control bit 7, read-latch mode |
| thr_sel | output | 1 | Control bit 6, threshold reference select |
| dac_code | output | 6 | Control bits 5..0, converter code |

## Verification
Each bus edge passes through two synchronizer flops and one edge-compare stage. The state register and the output registers therefore respond about three system clocks after the SCL or SDA change that causes them. Register loads and the read-address strobe follow the SCL fall after the eighth bit. The master-acknowledge strobe follows the rising SCL of the acknowledge clock. The bench drives the bus in quarter periods of eight clocks. It checks register contents and strobe counts only after the full acknowledge clock has finished. It samples the acknowledge and data bits in the middle of the SCL-high phase, well after the slave has settled.

// File: rtl/iox_pkg.sv
package iox_pkg;

    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 3;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [3:0] FIXED_ADDR_HI = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } iox_state_e;

endpackage

// File: rtl/iox_line_sampler.sv
module iox_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_hit,
    output logic stop_hit
);
    logic [STAGES-1:0] scl_sync;
    logic [STAGES-1:0] sda_sync;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[STAGES-2:0], sda_i};
            scl_prev <= scl_sync[STAGES-1];
            sda_prev <= sda_sync[STAGES-1];
        end
    end

    assign scl_now   = scl_sync[STAGES-1];
    assign sda_now   = sda_sync[STAGES-1];
    assign sda_lvl   = sda_now;
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_hit = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_hit  = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/iox_regs.sv
module iox_regs
    import iox_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int DAC_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_we,
    input  logic              ctrl_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PORT_W-1:0] port_out,
    output logic              latch_mode,
    output logic              thr_sel,
    output logic [DAC_W-1:0]  dac_code
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_out   <= '0;
            latch_mode <= 1'b0;
            thr_sel    <= 1'b0;
            dac_code   <= '0;
        end else begin
            if (port_we) begin
                port_out <= wdata[PORT_W-1:0];
            end
            if (ctrl_we) begin
                latch_mode <= wdata[BYTE_W-1];
                thr_sel    <= wdata[BYTE_W-2];
                dac_code   <= wdata[DAC_W-1:0];
            end
        end
    end

endmodule

// File: rtl/iox_slave.sv
module iox_slave
    import iox_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int DAC_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull,
    input  logic [STRAP_W-1:0] strap_a,
    input  logic [BYTE_W-1:0]  stat_byte,
    output logic               rd_strobe,
    output logic [PORT_W-1:0]  port_out,
    output logic               latch_mode,
    output logic               thr_sel,
    output logic [DAC_W-1:0]   dac_code
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    iox_state_e        state;
    iox_state_e        nstate;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic [1:0]        wr_cnt;
    logic              is_read;
    logic              mst_ack;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_hit;
    logic              stop_hit;
    logic              rx_full;
    logic              addr_hit;
    logic              byte_end;
    logic              port_we;
    logic              ctrl_we;

    iox_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_hit (start_hit),
        .stop_hit  (stop_hit)
    );

    assign rx_full  = (bit_cnt == FULL_CNT);
    assign addr_hit = (rx_sh[BYTE_W-1:1] == {FIXED_ADDR_HI, strap_a});
    assign byte_end = scl_fall & rx_full;
    assign port_we  = (state == ST_WR_BYTE) & byte_end & (wr_cnt == 2'd0);
    assign ctrl_we  = (state == ST_WR_BYTE) & byte_end & (wr_cnt == 2'd1);

    iox_regs #(.PORT_W(PORT_W), .DAC_W(DAC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_we    (port_we),
        .ctrl_we    (ctrl_we),
        .wdata      (rx_sh),
        .port_out   (port_out),
        .latch_mode (latch_mode),
        .thr_sel    (thr_sel),
        .dac_code   (dac_code)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // transitions
    always_comb begin
        nstate = state;
        if (stop_hit) begin
            nstate = ST_IDLE;
        end else if (start_hit) begin
            nstate = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nstate = ST_IDLE;
                ST_ADDR:     if (byte_end) nstate = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nstate = is_read ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) nstate = (wr_cnt < 2'd2) ? ST_WR_ACK : ST_IGNORE;
                ST_WR_ACK:   if (scl_fall) nstate = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bit_cnt == LAST_TX) nstate = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nstate = mst_ack ? ST_RD_BYTE : ST_IGNORE;
                ST_IGNORE:   nstate = ST_IGNORE;
                default:     nstate = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull = 1'b1;
            ST_RD_BYTE:             sda_pull = ~tx_sh[BYTE_W-1];
            default:                sda_pull = 1'b0;
        endcase
    end

    // shifters, counters and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh     <= '0;
            tx_sh     <= '1;
            bit_cnt   <= '0;
            wr_cnt    <= '0;
            is_read   <= 1'b0;
            mst_ack   <= 1'b0;
            rd_strobe <= 1'b0;
        end else begin
            rd_strobe <= 1'b0;
            if (start_hit) begin
                bit_cnt <= '0;
                wr_cnt  <= '0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_end) begin
                            is_read   <= rx_sh[0];
                            rd_strobe <= addr_hit & rx_sh[0];
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_end) begin
                            wr_cnt <= wr_cnt + 1'b1;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (is_read) begin
                                tx_sh <= stat_byte;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b1};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mst_ack   <= ~sda_lvl;
                            rd_strobe <= ~sda_lvl;
                        end
                        if (scl_fall && mst_ack) begin
                            tx_sh   <= stat_byte;
                            bit_cnt <= '0;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

module iox_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_rise,
    input logic       scl_fall,
    input logic       start_hit,
    input logic       stop_hit,
    input logic       sda_pull,
    input logic       rd_strobe,
    input logic [7:0] port_out,
    input logic [7:0] ctrl_view
);
    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);

    // R9
    strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> ($past(scl_rise) || $past(scl_fall)));

    // R4
    port_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_out != $past(port_out)) |-> $past(scl_fall));

    // R5
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_view != $past(ctrl_view)) |-> $past(scl_fall));

    // R2
    pull_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> ($past(scl_fall) || $past(start_hit) || $past(stop_hit)));

endmodule

bind iox_slave iox_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_hit (start_hit),
    .stop_hit  (stop_hit),
    .sda_pull  (sda_pull),
    .rd_strobe (rd_strobe),
    .port_out  (port_out),
    .ctrl_view ({latch_mode, thr_sel, dac_code})
);

// File: tb/iox_slave_test.sv
module iox_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam logic [2:0] STRAP = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic       rd_strobe;
    logic [7:0] port_out;
    logic       latch_mode;
    logic       thr_sel;
    logic [5:0] dac_code;
    logic [7:0] stat;
    logic       sda_line;
    int         strobes = 0;
    int         tests = 0;
    int         fails = 0;
    bit         finished = 1'b0;

    assign sda_line = sda_m & ~sda_pull;

    function automatic logic [7:0] stat_of(input int n);
        logic [7:0] v;
        v = n[7:0];
        return 8'h5A ^ (v * 8'd29);
    endfunction

    assign stat = stat_of(strobes);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rd_strobe) strobes = strobes + 1;

    iox_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull   (sda_pull),
        .strap_a    (STRAP),
        .stat_byte  (stat),
        .rd_strobe  (rd_strobe),
        .port_out   (port_out),
        .latch_mode (latch_mode),
        .thr_sel    (thr_sel),
        .dac_code   (dac_code)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q();
        s = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            b = {b[6:0], s};
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic t_reset();
        check_eq("R1 port_out", port_out, 8'h00);
        check_eq("R1 control", {latch_mode, thr_sel, dac_code}, 8'h00);
        check_eq("R1 sda_pull", sda_pull, 1'b0);
        check_eq("R1 rd_strobe", rd_strobe, 1'b0);
    endtask

    task automatic t_write_one();
        logic a;
        bus_start();
        put_byte({4'b0111, STRAP, 1'b0}, a);
        check_eq("R2 write addr ack", a, 1'b1);
        put_byte(8'hC3, a);
        check_eq("R4 byte1 ack", a, 1'b1);
        check_eq("R4 port_out", port_out, 8'hC3);
        check_eq("R6 control untouched", {latch_mode, thr_sel, dac_code}, 8'h00);
        bus_stop();
    endtask

    task automatic t_write_two();
        logic a;
        bus_start();
        put_byte({4'b0111, STRAP, 1'b0}, a);
        put_byte(8'h3C, a);
        put_byte(8'hA9, a);
        check_eq("R5 byte2 ack", a, 1'b1);
        check_eq("R4 port_out two-byte", port_out, 8'h3C);
        check_eq("R5 latch_mode", latch_mode, 1'b1);
        check_eq("R5 thr_sel", thr_sel, 1'b0);
        check_eq("R5 dac_code", dac_code, 6'h29);
        bus_stop();
        bus_start();
        put_byte({4'b0111, STRAP, 1'b0}, a);
        put_byte(8'h3C, a);
        put_byte(8'h7F, a);
        check_eq("R5 control second", {latch_mode, thr_sel, dac_code}, 8'h7F);
        put_byte(8'h00, a);
        check_eq("R7 third byte nack", a, 1'b0);
        check_eq("R7 control kept", {latch_mode, thr_sel, dac_code}, 8'h7F);
        check_eq("R7 port kept", port_out, 8'h3C);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        put_byte({4'b0111, 3'b100, 1'b0}, a);
        check_eq("R3 strap mismatch nack", a, 1'b0);
        put_byte(8'h11, a);
        check_eq("R3 later byte nack", a, 1'b0);
        check_eq("R3 port kept", port_out, 8'h3C);
        bus_stop();
        bus_start();
        put_byte({4'b0110, STRAP, 1'b0}, a);
        check_eq("R3 high nibble mismatch nack", a, 1'b0);
        put_byte(8'h22, a);
        check_eq("R3 port kept 2", port_out, 8'h3C);
        bus_stop();
    endtask

    task automatic t_abort();
        logic a;
        logic s;
        bus_start();
        put_byte({4'b0111, STRAP, 1'b0}, a);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        bus_stop();
        check_eq("R10 stop abort port kept", port_out, 8'h3C);
        bus_start();
        put_byte({4'b0111, STRAP, 1'b0}, a);
        for (int i = 0; i < 5; i++) clk_bit(1'b1, s);
        bus_start();
        check_eq("R10 restart abort port kept", port_out, 8'h3C);
        put_byte({4'b0111, STRAP, 1'b0}, a);
        check_eq("R10 restart addr ack", a, 1'b1);
        put_byte(8'h81, a);
        check_eq("R10 restart write", port_out, 8'h81);
        bus_stop();
    endtask

    task automatic t_read_multi();
        logic a;
        logic [7:0] b;
        int s0;
        s0 = strobes;
        bus_start();
        put_byte({4'b0111, STRAP, 1'b1}, a);
        check_eq("R2 read addr ack", a, 1'b1);
        check_eq("R9 strobe at addr ack", strobes, s0 + 1);
        get_byte(1'b1, b);
        check_eq("R8 read byte 1", b, stat_of(s0 + 1));
        check_eq("R9 strobe at master ack", strobes, s0 + 2);
        get_byte(1'b1, b);
        check_eq("R8 read byte 2", b, stat_of(s0 + 2));
        get_byte(1'b0, b);
        check_eq("R8 read byte 3", b, stat_of(s0 + 3));
        check_eq("R9 no strobe on nack", strobes, s0 + 3);
        get_byte(1'b0, b);
        check_eq("R11 released after nack", b, 8'hFF);
        bus_stop();
        check_eq("R11 sda_pull idle", sda_pull, 1'b0);
    endtask

    task automatic t_read_single();
        logic a;
        logic [7:0] b;
        int s0;
        s0 = strobes;
        bus_start();
        put_byte({4'b0111, STRAP, 1'b1}, a);
        get_byte(1'b0, b);
        check_eq("R8 single read", b, stat_of(s0 + 1));
        check_eq("R9 single read strobes", strobes, s0 + 1);
        bus_stop();
        check_eq("R8 read leaves port", port_out, 8'h81);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_one();
        t_write_two();
        t_mismatch();
        t_abort();
        t_read_multi();
        t_read_single();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule